// File: doc/BRIEF.md
# Codec Sample Register Interface

This block sits between a processor bus and the sample streams of an audio converter. A single data address carries both directions. A bus read there returns the newest sample captured from the analog-to-digital side. A bus write there loads the word that the digital-to-analog side will take next. Two further addresses hold a read-write control word and a read-only status word.

Four status flags track the data flow. The converter side sets them through one-cycle strobes, and ordinary data accesses clear them as a side effect, so software needs no separate acknowledge. When the interrupt enable is set, an interrupt request is raised while a sample waits to be read or while the transmit slot waits for data.

Gain, mute, rate, input and volume fields are stored and driven out unchanged. Their meaning belongs to the converter, not to this block.

Top module: `codec_regif`

## Requirements
- R1: Address 0 is control, 1 is status and 2 is data. A read at address 3 returns zero. A cycle with `cs` and `wr` both high is a write, even if `rd` is also high. The data address returns the receive register on a read and loads the transmit register on a write. `dac_data` always shows the transmit register.
- R2: An `adc_valid` pulse loads `adc_data` into the receive register whether or not the codec is enabled. When the codec is enabled, the pulse also sets receive-full (status bit 3).
- R3: A read of the data address clears receive-full, unless `adc_valid` arrives in the same cycle.
- R4: The control word has these fields: bit 15 interrupt enable, bit 14 codec enable, bit 13 input select, bits 12:11 gain, bit 10 mute, bits 9:8 rate, bits 3:0 volume. Each field drives its own output. Bits 7:4 read as zero and ignore writes. The control word resets to 0.
- R5: The status word carries receive-full in bit 3, transmit-empty in bit 2, receive-overrun in bit 1 and transmit-underrun in bit 0. Bits 15:4 read as zero. Writes to the status address change nothing.
- R6: A `dac_take` pulse sets transmit-empty. A write to the data address clears it, and the write wins when both happen in the same cycle.
- R7: An `adc_valid` pulse while receive-full is set, with no data read in that cycle, sets receive-overrun. The new sample replaces the old one. Receive-overrun clears on a data read that follows a status read which showed it set.
- R8: A `dac_take` pulse while transmit-empty is set sets transmit-underrun, and `dac_data` keeps its previous value. Transmit-underrun clears on a data write that follows a status read which showed it set. A new underrun in the same cycle takes precedence over the clear.
- R9: `irq` equals interrupt enable AND codec enable AND (receive-full OR transmit-empty).
- R10: While codec enable is 0, the flags take their reset values from the next cycle onward: transmit-empty 1, all other flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and converter strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Bus chip select |
| rd | input | 1 | Bus read strobe |
| wr | input | 1 | Bus write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Bus write data |
| rdata | output | DW | Bus read data, combinational, zero when no read |
| adc_valid | input | 1 | One-cycle pulse: new converter sample |
| adc_data | input | DW | Sample from the decimation filter |
| dac_take | input | 1 | One-cycle pulse: output path takes a sample |
| dac_data | output | DW | Transmit register contents |
| irq | output | 1 | Interrupt request |
| ctl_en | output | 1 | Codec enable field |
| ctl_insel | output | 1 | Input select field |
| ctl_gain | output | 2 | Gain select field |
| ctl_mute | output | 1 | Mute field |
| ctl_rate | output | 2 | Rate select field |
| ctl_vol | output | 4 | Volume field |

## Verification
The bench targets several corner cases, and each one exposes a specific design mistake:

- **Same-cycle sample and read.** A sample arriving in the same cycle as a data read must leave receive-full set without an overrun. A design with the wrong priority would either lose the flag or raise a false overrun.
- **Clear sequences.** The sticky error flags are tested with and without the preceding status read. A design that dropped the arming step would clear overrun or underrun on a bare data access.
- **Disabling the codec.** Clearing codec enable while flags are set must return all flags to their reset values. A design that only froze the flags would keep raising status.
- **Reserved bits and read-only status.** Writing all ones to the reserved control bits and to the status address must leave nothing changed. A design that stored those bits would return nonzero values on read.

Long random traffic, including collisions between strobes and control writes, is compared cycle by cycle against a reference model built from the requirements.

// File: rtl/codec_regif.sv
module codec_regif #(
  parameter int DW       = 16,
  parameter int AW       = 2,
  parameter int CTL_ADDR = 0,
  parameter int STS_ADDR = 1,
  parameter int DAT_ADDR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          adc_valid,
  input  logic [DW-1:0] adc_data,
  input  logic          dac_take,
  output logic [DW-1:0] dac_data,
  output logic          irq,
  output logic          ctl_en,
  output logic          ctl_insel,
  output logic [1:0]    ctl_gain,
  output logic          ctl_mute,
  output logic [1:0]    ctl_rate,
  output logic [3:0]    ctl_vol
);
  localparam logic [15:0] CTL_MASK = 16'hFF0F;
  localparam int          PADW     = DW - 4;

  logic [15:0]   ctl_q;
  logic [DW-1:0] rx_q, tx_q;
  logic rdf, tde, rovr, tund, ovr_arm, und_arm;

  wire bus_wr = cs & wr;
  wire bus_rd = cs & rd & ~wr;
  wire wr_ctl = bus_wr & (addr == AW'(CTL_ADDR));
  wire wr_tx  = bus_wr & (addr == AW'(DAT_ADDR));
  wire rd_sts = bus_rd & (addr == AW'(STS_ADDR));
  wire rd_rx  = bus_rd & (addr == AW'(DAT_ADDR));
  wire rd_ctl = bus_rd & (addr == AW'(CTL_ADDR));

  wire ctl_ie = ctl_q[15];
  assign ctl_en    = ctl_q[14];
  assign ctl_insel = ctl_q[13];
  assign ctl_gain  = ctl_q[12:11];
  assign ctl_mute  = ctl_q[10];
  assign ctl_rate  = ctl_q[9:8];
  assign ctl_vol   = ctl_q[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      if (wr_ctl)    ctl_q <= wdata[15:0] & CTL_MASK;
      if (adc_valid) rx_q  <= adc_data;
      if (wr_tx)     tx_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf <= 1'b0; tde <= 1'b1; rovr <= 1'b0; tund <= 1'b0;
      ovr_arm <= 1'b0; und_arm <= 1'b0;
    end else if (!ctl_en) begin
      rdf <= 1'b0; tde <= 1'b1; rovr <= 1'b0; tund <= 1'b0;
      ovr_arm <= 1'b0; und_arm <= 1'b0;
    end else begin
      rdf <= adc_valid | (rdf & ~rd_rx);
      tde <= ~wr_tx & (dac_take | tde);

      if (adc_valid & rdf & ~rd_rx) rovr <= 1'b1;
      else if (rd_rx & ovr_arm)     rovr <= 1'b0;
      if (rd_sts)     ovr_arm <= rovr;
      else if (rd_rx) ovr_arm <= 1'b0;

      if (dac_take & tde)       tund <= 1'b1;
      else if (wr_tx & und_arm) tund <= 1'b0;
      if (rd_sts)     und_arm <= tund;
      else if (wr_tx) und_arm <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_ctl)      rdata[15:0] = ctl_q;
    else if (rd_sts) rdata = {{PADW{1'b0}}, rdf, tde, rovr, tund};
    else if (rd_rx)  rdata = rx_q;
  end

  assign dac_data = tx_q;
  assign irq      = ctl_ie & ctl_en & (rdf | tde);

  p_rdf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid && ctl_en && !wr_ctl |=> rdf);
  p_rdf_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !adc_valid |=> !rdf);
  p_tde_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx && ctl_en && !wr_ctl |=> !tde);
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid && rdf && !rd_rx && ctl_en && !wr_ctl |=> rovr);
  p_und_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dac_take && tde && ctl_en && !wr_ctl |=> tund);
  p_dac_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tx |=> $stable(dac_data));
  p_sts_rsv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts |-> rdata[DW-1:4] == '0);
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_en);
  p_dis_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (!rdf && tde && !rovr && !tund));
endmodule

// File: tb/sim_codec_regif.sv
`timescale 1ns/1ps
module sim_codec_regif;
  logic clk = 0, rst_n = 0;
  logic cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, adc_data = 0;
  logic adc_valid = 0, dac_take = 0;
  logic [15:0] rdata, dac_data;
  logic irq, ctl_en, ctl_insel, ctl_mute;
  logic [1:0] ctl_gain, ctl_rate;
  logic [3:0] ctl_vol;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  codec_regif u0 (.clk, .rst_n, .cs, .rd, .wr, .addr, .wdata, .rdata,
    .adc_valid, .adc_data, .dac_take, .dac_data, .irq, .ctl_en, .ctl_insel,
    .ctl_gain, .ctl_mute, .ctl_rate, .ctl_vol);

  logic [15:0] m_ctl = 0, m_rx = 0, m_tx = 0;
  bit m_rdf = 0, m_tde = 1, m_ovr = 0, m_und = 0, m_oarm = 0, m_uarm = 0;

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctl;
      2'd1: return {12'd0, m_rdf, m_tde, m_ovr, m_und};
      2'd2: return m_rx;
      default: return 16'd0;
    endcase
  endfunction

  function automatic bit exp_irq();
    return m_ctl[15] & m_ctl[14] & (m_rdf | m_tde);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit c, r, w, input logic [1:0] a,
                            input logic [15:0] d, input bit av,
                            input logic [15:0] ad, input bit tk);
    bit wtx = c & w & (a == 2);
    bit rrx = c & r & !w & (a == 2);
    bit rst = c & r & !w & (a == 1);
    bit en = m_ctl[14];
    bit n_ovr = m_ovr, n_und = m_und, n_oarm = m_oarm, n_uarm = m_uarm;
    if (en) begin
      if (av && m_rdf && !rrx) n_ovr = 1; else if (rrx && m_oarm) n_ovr = 0;
      if (rst) n_oarm = m_ovr; else if (rrx) n_oarm = 0;
      if (tk && m_tde) n_und = 1; else if (wtx && m_uarm) n_und = 0;
      if (rst) n_uarm = m_und; else if (wtx) n_uarm = 0;
      m_rdf = av | (m_rdf & !rrx);
      m_tde = !wtx & (tk | m_tde);
      m_ovr = n_ovr; m_und = n_und; m_oarm = n_oarm; m_uarm = n_uarm;
    end else begin
      m_rdf = 0; m_tde = 1; m_ovr = 0; m_und = 0; m_oarm = 0; m_uarm = 0;
    end
    if (c && w && a == 0) m_ctl = d & 16'hFF0F;
    if (av) m_rx = ad;
    if (wtx) m_tx = d;
  endtask

  task automatic step(input bit c, r, w, input logic [1:0] a,
                      input logic [15:0] d, input bit av,
                      input logic [15:0] ad, input bit tk, input string tag = "");
    @(negedge clk);
    cs = c; rd = r; wr = w; addr = a; wdata = d;
    adc_valid = av; adc_data = ad; dac_take = tk;
    #1;
    if (c && r && !w)
      check(tag != "" ? tag : (a == 0 ? "R4" : a == 1 ? "R5" : a == 2 ? "R2" : "R1"),
            rdata, exp_rd(a));
    else check("R1 idle rdata", rdata, 16'd0);
    check("R9 irq", {15'd0, irq}, {15'd0, exp_irq()});
    check("R8 dac_data", dac_data, m_tx);
    check("R4 fields", {ctl_en, ctl_insel, ctl_gain, ctl_mute, ctl_rate, ctl_vol},
          {m_ctl[14:8], m_ctl[3:0]});
    @(posedge clk);
    model_edge(c, r, w, a, d, av, ad, tk);
  endtask

  task automatic bus_rd(input logic [1:0] a, input string tag = "");
    step(1, 1, 0, a, 16'h0, 0, 16'h0, 0, tag);
  endtask
  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    step(1, 0, 1, a, d, 0, 16'h0, 0);
  endtask
  task automatic idle(input bit av = 0, input logic [15:0] ad = 0, input bit tk = 0);
    step(0, 0, 0, 2'd0, 16'h0, av, ad, tk);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state: ctl 0, status 0x0004
    bus_rd(2'd1, "R10 reset status");
    bus_rd(2'd0, "R10 reset control");
    // R4 reserved control bits ignored
    bus_wr(2'd0, 16'hFFFF);
    bus_rd(2'd0, "R4 reserved bits");
    // R5 status write ignored
    bus_wr(2'd1, 16'hFFFF);
    bus_rd(2'd1, "R5 status read-only");
    bus_rd(2'd3, "R1 unused address");
    // R2 / R3 load then read
    bus_wr(2'd0, 16'hC000);
    idle(1, 16'hA5A5);
    bus_rd(2'd1, "R2 rdf set");
    bus_rd(2'd2, "R2 rx data");
    bus_rd(2'd1, "R3 rdf clear");
    // R3 read collides with new sample: rdf stays, no overrun
    idle(1, 16'h1111);
    step(1, 1, 0, 2'd2, 0, 1, 16'h2222, 0, "R3 collide read");
    bus_rd(2'd1, "R3 collide status");
    // R7 overrun, clear needs status read first
    idle(1, 16'h3333);
    bus_rd(2'd2, "R7 overwritten sample");
    idle(1, 16'h4444);
    idle(1, 16'h5555);
    bus_rd(2'd2, "R7 bare read");
    bus_rd(2'd1, "R7 ovr still set");
    bus_rd(2'd2, "R7 armed read");
    bus_rd(2'd1, "R7 ovr cleared");
    // R6 / R8 transmit path
    bus_wr(2'd2, 16'hBEEF);
    bus_rd(2'd1, "R6 tde cleared");
    idle(0, 0, 1);
    bus_rd(2'd1, "R6 tde set");
    idle(0, 0, 1);
    bus_rd(2'd1, "R8 underrun set");
    bus_wr(2'd2, 16'h0101);
    bus_rd(2'd1, "R8 und after armed write");
    idle(0, 0, 1);
    idle(0, 0, 1);
    bus_wr(2'd2, 16'h0202);
    bus_rd(2'd1, "R8 und bare write kept");
    step(1, 0, 1, 2'd2, 16'h0303, 0, 0, 1);
    bus_rd(2'd1, "R6 write wins take");
    // R10 disable clears flags
    idle(1, 16'h7777);
    bus_wr(2'd0, 16'h8000);
    idle(1, 16'h8888, 1);
    bus_rd(2'd1, "R10 flags held");
    bus_rd(2'd2, "R2 load while disabled");
    // random traffic
    begin
      int unsigned s = $urandom(32'd20240611);
      s = s;
    end
    for (int i = 0; i < 4000; i++) begin
      bit c = ($urandom % 4) != 0;
      bit w = ($urandom % 3) == 0;
      bit r = ($urandom % 2) == 0;
      logic [1:0] a = 2'($urandom);
      logic [15:0] d = 16'($urandom);
      if (c && w && a == 0 && ($urandom % 8) != 0) d[14] = 1'b1;
      step(c, r, w, a, d, ($urandom % 3) == 0, 16'($urandom),
           ($urandom % 3) == 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule